// File: doc/BRIEF.md
# Video Encoder Reset Conditioner and Strap Configuration

This block sits between the board-level reset pad of a video encoder and the rest of the chip. It watches an asynchronous active-low pad reset on the crystal clock. It throws away lows that are too short. When a low is accepted, it raises an internal reset and holds it for a fixed number of crystal clocks after the pad goes high again.

While the internal reset is high, the block makes the sync, colour-bar and teletext-reset pins inputs and turns off the two composite-sync output drivers. On the first cycle of an accepted pad reset, it tells the control bus interface to drop any transfer in progress.

When the internal reset is released, the block loads five configuration bits from strap pins. Those bits then stay in force until the control bus writes new values. The bits cover the video standard, the input format, the demultiplex phase and the sync master/slave choice. The sync pin directions follow the master/slave bit.

Top module: `vrst_strap_ctrl`

## Requirements
- R1: The pad reset `ext_rst_ni` is first passed through a 2-flop synchronizer. A pad low counts only if its synchronized value is low on at least 2 consecutive clock edges. A low that covers only one rising edge changes nothing: `int_rst_o` stays 0, `bus_abort_o` stays 0 and the configuration is unchanged.
- R2: Count the rising edges from the first one that samples the pad high again. `int_rst_o` falls on the 34th of these edges: 2 synchronizer edges plus a 32-clock extension. The same count applies after `rst_ni` is released with the pad already high.
- R3: `pin_oe_o` order is bit 0 frame sync, bit 1 vertical sync, bit 2 horizontal sync, bit 3 colour bar, bit 4 teletext reset. While `int_rst_o` is 1, all five bits are 0. Afterwards, bits 2:0 equal the master bit and bits 4:3 are 1.
- R4: `csync_oe_o` (bit 0 composite sync, bit 1 vertical sync output) is 00 while `int_rst_o` is 1 and 11 afterwards.
- R5: `bus_abort_o` is 1 for exactly one cycle for each accepted pad reset: the first cycle in which `int_rst_o` is 1. It is never raised by `rst_ni`.
- R6: Strap bits are: bit 0 standard (0 NTSC-M, 1 PAL-B/G), bit 1 input format (0 4:2:2 YCbCr, 1 4:4:4 RGB), bits 3:2 demultiplex phase, bit 4 sync master (1) or slave (0). They are taken on the clock edge on which `int_rst_o` falls. Strap changes after that edge have no effect.
- R7: When `cfg_we_i` is 1 and `int_rst_o` is 0, each bit set in `cfg_wmask_i` takes the matching `cfg_wdata_i` bit on the next edge. Every other bit keeps its strapped or last written value.
- R8: A synchronized low seen during the extension restarts the count. `int_rst_o` then falls on the 34th rising edge after the pad is sampled high again.
- R9: While `rst_ni` is 0: `int_rst_o` is 1, all configuration outputs are 0, `bus_abort_o` is 0, and all pin enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Chip power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | Pad reset request, active low, asynchronous to clk_i |
| strap_i | input | 5 | Strap pin levels (bit map in R6) |
| cfg_we_i | input | 1 | Configuration write strobe from the control bus |
| cfg_wmask_i | input | 5 | Per-bit write enable |
| cfg_wdata_i | input | 5 | Write data, same bit map as strap_i |
| int_rst_o | output | 1 | Stretched internal reset, active high |
| bus_abort_o | output | 1 | One-cycle abort strobe to the control bus interface |
| pin_oe_o | output | 5 | Output enables of the sync, colour-bar and teletext-reset pins |
| csync_oe_o | output | 2 | Output enables of the composite and vertical sync drivers |
| std_pal_o | output | 1 | 1 selects PAL-B/G, 0 selects NTSC-M |
| fmt_rgb_o | output | 1 | 1 selects 4:4:4 RGB input, 0 selects 4:2:2 YCbCr |
| demux_ph_o | output | 2 | Input demultiplex phase |
| sync_master_o | output | 1 | 1 makes the sync pins outputs |

## Verification
The bench sweeps pad low lengths from one edge up to several. A qualifier that is off by one would accept the one-edge glitch, or would raise the abort a cycle late. It measures the exact falling edge of the internal reset after each release and after a glitch inside the extension. A stretch counter that starts too early, or is not restarted by the glitch, ends the reset at the wrong edge.

All 32 strap values are applied, each with its own write mask. A strap sampled one edge late would miss a value changed just before release, and would pick up one changed just after. A write that ignores its mask would disturb the bits that should keep their strapped level.

// File: rtl/vrst_pkg.sv
package vrst_pkg;
  localparam int unsigned CFG_W      = 5;
  localparam int unsigned PIN_N      = 5;
  localparam int unsigned SYNC_PIN_N = 3;
  localparam int unsigned CSYNC_N    = 2;

  typedef struct packed {
    logic       master;
    logic [1:0] demux_ph;
    logic       fmt_rgb;
    logic       std_pal;
  } cfg_t;
endpackage

// File: rtl/vrst_sync.sv
module vrst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vrst_qual.sv
module vrst_qual #(
  parameter int unsigned MIN_LOW = 2,
  parameter int unsigned STRETCH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_hi_i,
  output logic act_o,
  output logic abort_o,
  output logic release_o
);
  localparam int unsigned LW = $clog2(MIN_LOW + 1);
  localparam int unsigned SW = $clog2(STRETCH + 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(MIN_LOW - 1);
  localparam logic [SW-1:0] STR_LAST = SW'(STRETCH - 1);

  logic [LW-1:0] low_cnt_q;
  logic [SW-1:0] str_cnt_q;
  logic          act_q, abort_q;
  logic          qual;

  assign qual      = !pad_hi_i && (low_cnt_q == LOW_LAST);
  assign release_o = act_q && pad_hi_i && (str_cnt_q == STR_LAST);

  // low run length, saturating at the qualify point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_cnt_q <= LOW_LAST;
    else if (pad_hi_i)      low_cnt_q <= '0;
    else if (!qual)         low_cnt_q <= low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b1;
      str_cnt_q <= '0;
      abort_q   <= 1'b0;
    end else begin
      abort_q <= qual && !act_q;
      if (qual) begin
        act_q     <= 1'b1;
        str_cnt_q <= '0;
      end else if (act_q) begin
        if (!pad_hi_i)     str_cnt_q <= '0;   // restart on any low sample
        else if (release_o) begin
          act_q     <= 1'b0;
          str_cnt_q <= '0;
        end else           str_cnt_q <= str_cnt_q + 1'b1;
      end
    end
  end

  assign act_o   = act_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/vrst_cfg.sv
module vrst_cfg
  import vrst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             lock_i,
  input  logic [CFG_W-1:0] strap_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wmask_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  logic [CFG_W-1:0] bits_q;

  generate
    for (genvar b = 0; b < CFG_W; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          bits_q[b] <= 1'b0;
        else if (cap_i)                       bits_q[b] <= strap_i[b];
        else if (we_i && !lock_i && wmask_i[b]) bits_q[b] <= wdata_i[b];
      end
    end
  endgenerate

  assign cfg_o = cfg_t'(bits_q);
endmodule

// File: rtl/vrst_pinctl.sv
module vrst_pinctl
  import vrst_pkg::*;
(
  input  logic               act_i,
  input  logic               master_i,
  output logic [PIN_N-1:0]   pin_oe_o,
  output logic [CSYNC_N-1:0] csync_oe_o
);
  generate
    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
      if (p < SYNC_PIN_N) begin : g_sync
        assign pin_oe_o[p] = !act_i && master_i;
      end else begin : g_aux
        assign pin_oe_o[p] = !act_i;
      end
    end
    for (genvar c = 0; c < CSYNC_N; c++) begin : g_cs
      assign csync_oe_o[c] = !act_i;
    end
  endgenerate
endmodule

// File: rtl/vrst_strap_ctrl.sv
module vrst_strap_ctrl
  import vrst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 2,
  parameter int unsigned STRETCH     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_ni,
  input  logic [CFG_W-1:0]   strap_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wmask_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic               int_rst_o,
  output logic               bus_abort_o,
  output logic [PIN_N-1:0]   pin_oe_o,
  output logic [CSYNC_N-1:0] csync_oe_o,
  output logic               std_pal_o,
  output logic               fmt_rgb_o,
  output logic [1:0]         demux_ph_o,
  output logic               sync_master_o
);
  logic pad_hi, act, cap;
  cfg_t cfg;

  vrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ext_rst_ni), .q_o (pad_hi)
  );

  vrst_qual #(.MIN_LOW(MIN_LOW), .STRETCH(STRETCH)) u_qual (
    .clk_i (clk_i), .rst_ni (rst_ni), .pad_hi_i (pad_hi),
    .act_o (act), .abort_o (bus_abort_o), .release_o (cap)
  );

  vrst_cfg u_cfg (
    .clk_i (clk_i), .rst_ni (rst_ni), .cap_i (cap), .lock_i (act),
    .strap_i (strap_i), .we_i (cfg_we_i), .wmask_i (cfg_wmask_i),
    .wdata_i (cfg_wdata_i), .cfg_o (cfg)
  );

  vrst_pinctl u_pin (
    .act_i (act), .master_i (cfg.master),
    .pin_oe_o (pin_oe_o), .csync_oe_o (csync_oe_o)
  );

  assign int_rst_o     = act;
  assign std_pal_o     = cfg.std_pal;
  assign fmt_rgb_o     = cfg.fmt_rgb;
  assign demux_ph_o    = cfg.demux_ph;
  assign sync_master_o = cfg.master;
endmodule

// File: rtl/vrst_chk.sv
module vrst_chk #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 2,
  parameter int unsigned STRETCH     = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_ni,
  input logic       cfg_we_i,
  input logic       int_rst_o,
  input logic       bus_abort_o,
  input logic [4:0] pin_oe_o,
  input logic [1:0] csync_oe_o,
  input logic       std_pal_o,
  input logic       fmt_rgb_o,
  input logic [1:0] demux_ph_o,
  input logic       sync_master_o
);
  localparam int unsigned HOLD = SYNC_STAGES + STRETCH;
  localparam int unsigned CW   = $clog2(HOLD + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] hi_cnt, lo_cnt, last_lo;
  logic [5:0]    cfg_v;
  assign cfg_v = {sync_master_o, demux_ph_o, fmt_rgb_o, std_pal_o, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0; lo_cnt <= '0; last_lo <= '0;
    end else if (ext_rst_ni) begin
      if (hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
      if (lo_cnt != '0) last_lo <= lo_cnt;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != CMAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  AST_PINS_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> (pin_oe_o == '0) && (csync_oe_o == '0)); // R3 R4

  AST_ABORT_FIRST_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_abort_o |-> int_rst_o && !$past(int_rst_o)); // R5

  AST_STRETCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_rst_o) |-> (hi_cnt >= CW'(HOLD))); // R2

  AST_SHORT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_rst_o) |-> (lo_cnt >= CW'(MIN_LOW)) || (last_lo >= CW'(MIN_LOW))); // R1

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_rst_o && !cfg_we_i) |=> $stable(cfg_v)); // R7
endmodule

bind vrst_strap_ctrl vrst_chk #(
  .SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW), .STRETCH(STRETCH)
) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .ext_rst_ni (ext_rst_ni),
  .cfg_we_i (cfg_we_i), .int_rst_o (int_rst_o), .bus_abort_o (bus_abort_o),
  .pin_oe_o (pin_oe_o), .csync_oe_o (csync_oe_o), .std_pal_o (std_pal_o),
  .fmt_rgb_o (fmt_rgb_o), .demux_ph_o (demux_ph_o), .sync_master_o (sync_master_o)
);

// File: tb/tb_vrst_strap_ctrl.sv
module tb_vrst_strap_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, ext_n, we;
  logic [4:0] strap, wmask, wdata;
  logic       int_rst, abort, std_pal, fmt_rgb, master;
  logic [4:0] pin_oe;
  logic [1:0] csync_oe, demux;
  logic [4:0] cfg_v;

  int n_chk = 0, n_bad = 0, abort_cnt = 0, rst_hi_cnt = 0;

  always #4 clk = ~clk;

  vrst_strap_ctrl dut (
    .clk_i (clk), .rst_ni (rst_n), .ext_rst_ni (ext_n), .strap_i (strap),
    .cfg_we_i (we), .cfg_wmask_i (wmask), .cfg_wdata_i (wdata),
    .int_rst_o (int_rst), .bus_abort_o (abort), .pin_oe_o (pin_oe),
    .csync_oe_o (csync_oe), .std_pal_o (std_pal), .fmt_rgb_o (fmt_rgb),
    .demux_ph_o (demux), .sync_master_o (master)
  );

  assign cfg_v = {master, demux, fmt_rgb, std_pal};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (abort)   abort_cnt++;
      if (int_rst) rst_hi_cnt++;
    end
  endtask

  task automatic wait_release(input string req);
    tick(33);
    chk(req, int_rst, 1);
    tick(1);
    chk(req, int_rst, 0);
  endtask

  task automatic chk_pins(input logic m);
    chk("R3 pin_oe", pin_oe, m ? 5'b11111 : 5'b11000);
    chk("R4 csync_oe", csync_oe, 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; ext_n = 1; we = 0; wmask = '0; wdata = '0; strap = 5'b10110;
    tick(2);
    chk("R9 int_rst", int_rst, 1);
    chk("R9 cfg", cfg_v, 0);
    chk("R9 abort", abort, 0);
    chk("R3 pin_oe in reset", pin_oe, 0);
    chk("R4 csync_oe in reset", csync_oe, 0);
    rst_n = 1;
    abort_cnt = 0;
    wait_release("R2 power-on release");
    chk("R6 power-on strap", cfg_v, 5'b10110);
    chk("R5 no abort from rst_ni", abort_cnt, 0);
    chk_pins(1'b1);

    // pad low length sweep
    for (int len = 1; len <= 4; len++) begin
      abort_cnt = 0; rst_hi_cnt = 0;
      ext_n = 0; tick(len); ext_n = 1;
      if (len < 2) begin
        tick(40);
        chk("R1 glitch int_rst", rst_hi_cnt, 0);
        chk("R1 glitch abort", abort_cnt, 0);
        chk("R1 glitch cfg", cfg_v, 5'b10110);
      end else begin
        wait_release("R2 pad release");
        chk("R2 reset length", rst_hi_cnt, len + 30);
        chk("R5 abort count", abort_cnt, 1);
      end
    end

    // exact abort cycle
    ext_n = 0; tick(3);
    chk("R1 not yet qualified", int_rst, 0);
    tick(1);
    chk("R1 qualified", int_rst, 1);
    chk("R5 abort first cycle", abort, 1);
    tick(1);
    chk("R5 abort one cycle", abort, 0);
    ext_n = 1;
    wait_release("R2 after long low");

    // glitch inside extension restarts the count
    ext_n = 0; tick(2); ext_n = 1;
    tick(10);
    ext_n = 0; tick(1); ext_n = 1;
    wait_release("R8 restart");

    // capture edge
    strap = 5'b00001;
    ext_n = 0; tick(2); ext_n = 1;
    tick(33);
    chk("R2 still in reset", int_rst, 1);
    strap = 5'b11010;
    tick(1);
    chk("R6 capture at release edge", cfg_v, 5'b11010);
    strap = 5'b00101;
    tick(2);
    chk("R6 later strap ignored", cfg_v, 5'b11010);

    // full strap sweep with masked writes
    for (int s = 0; s < 32; s++) begin
      logic [4:0] sv, mv;
      sv = 5'(s);
      mv = 5'((s * 7 + 3) % 32);
      strap = sv;
      ext_n = 0; tick(2); ext_n = 1;
      wait_release("R2 sweep release");
      chk("R6 strap sweep", cfg_v, sv);
      chk_pins(sv[4]);
      strap = ~sv;
      tick(2);
      chk("R6 strap frozen", cfg_v, sv);
      we = 1; wmask = mv; wdata = ~sv;
      tick(1);
      we = 0;
      chk("R7 masked write", cfg_v, sv ^ mv);
      chk("R3 pins follow master", pin_oe, (sv[4] ^ mv[4]) ? 5'b11111 : 5'b11000);
      tick(3);
      chk("R7 value held", cfg_v, sv ^ mv);
    end

    // power-on reset mid-run
    rst_n = 0; tick(1);
    chk("R9 mid-run cfg", cfg_v, 0);
    chk("R9 mid-run int_rst", int_rst, 1);
    rst_n = 1; strap = 5'b01100;
    wait_release("R2 second power-on");
    chk("R6 second power-on strap", cfg_v, 5'b01100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule